// File: doc/BRIEF.md
# Two-Wire Register Slave with Saturating Pointer

This block is a slave on a two-wire serial bus (SCL clock, SDA data). It answers to one fixed 7-bit device address and holds a file of 23 eight-bit registers, numbered 0x00 to 0x16. A master selects a register by sending a pointer byte after the address. It then writes one or more bytes, or it issues a repeated START and reads the register contents back. The pointer steps forward after every byte but stops at the last register, so long bursts keep hitting register 0x16.

Both bus lines are sampled by a fast system clock through two-flop synchronizers. The system clock must be at least 8 MHz for fast-mode bus rates up to 400 kbit/s. SDA is driven only as an open-drain pull-down enable, so `sdaOe` high means the slave pulls the line low. The block never stretches the clock and answers no general call.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset `sdaOe` is 0, every register reads 0x00 and the pointer is 0x00, so a read with no pointer phase returns register 0x00 first.
- R2: The slave acknowledges (pulls SDA low for the whole 9th clock) only an address byte whose upper seven bits are 7'b1100011; bit 0 of that byte is R/W (1 = read). For any other address it acknowledges nothing, drives nothing and changes no register or pointer until the next START or STOP.
- R3: SDA falling while SCL is high is a START and always restarts the address phase, even in mid-transfer; SDA rising while SCL is high is a STOP and returns the slave to idle. A START directly followed by a STOP is harmless.
- R4: In a write, the first byte after the address loads the pointer (values above 0x16 load 0x16), and each later byte is stored in the pointed register; every one of these bytes is acknowledged.
- R5: The pointer advances by one after each data byte written and after each byte read, and stays at 0x16 once it gets there.
- R6: A repeated START with R/W=1 after a pointer byte starts a read of the pointed register. Data goes out MSB first, a 0 bit pulls SDA low and a 1 bit releases it.
- R7: A read addressed directly after START, with no pointer byte, starts at the pointer left by the last access.
- R8: When the master does not acknowledge a read byte (SDA high in the 9th clock), the slave releases SDA and stays off the bus until the next START or STOP.
- R9: `sdaOe` changes only while SCL is low; it is constant through every SCL high phase.
- R10: A repeated START with R/W=0 begins a fresh write whose first byte is again a pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen on the pin |
| sdaIn | input | 1 | Bus data line as seen on the pin |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Storing a received byte and advancing the pointer happen on the same system-clock edge. At the top of the register file the advance must give way to saturation while the store still lands. The bench provokes this with a write burst that runs from 0x14 past 0x16, and with a pointer byte above the range. A behavioural model of the registers and the pointer then predicts every bit of later random and current-address reads. The model is compared against `sdaOe` on each system clock of every SCL high phase.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  // strobes from the bus controller to the datapath, one bit per action
  typedef struct packed {
    logic shiftIn;   // sample SDA into the receive shifter
    logic loadPtr;   // received byte becomes the register pointer
    logic writeReg;  // received byte goes into the pointed register
    logic loadTx;    // pointed register goes into the transmit shifter
    logic shiftTx;   // move to the next transmit bit
    logic incPtr;    // advance the pointer (saturating)
  } dpStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RX_ACK, S_TX, S_TX_ACK, S_SKIP
  } busState_t;

  typedef enum logic [1:0] {
    PH_ADDR, PH_PTR, PH_DATA
  } phase_t;

endpackage

// File: rtl/i2c_slave_dpath.sv
module i2c_slave_dpath
  import i2c_reg_pkg::*;
#(
  parameter int NUM_REGS = 23
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic       sdaBit,
  output logic [7:0] rxByte,
  output logic       txBit
);

  localparam int BYTE_W = 8;
  localparam int PTR_W  = $clog2(NUM_REGS);
  localparam int LAST   = NUM_REGS - 1;

  logic [BYTE_W-1:0] rxSr;
  logic [BYTE_W-1:0] txSr;
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] regs [NUM_REGS];
  logic [BYTE_W-1:0] rdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSr <= '0;
    else if (strobe.shiftIn) rxSr <= {rxSr[BYTE_W-2:0], sdaBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobe.loadPtr) begin
      ptr <= (int'(rxSr) > LAST) ? PTR_W'(LAST) : rxSr[PTR_W-1:0];
    end else if (strobe.incPtr && (ptr != PTR_W'(LAST))) begin
      ptr <= ptr + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regs[i] <= '0;
      else if (strobe.writeReg && (ptr == PTR_W'(i))) regs[i] <= rxSr;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ptr == PTR_W'(i)) rdData = regs[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txSr <= '1;
    else if (strobe.loadTx) txSr <= rdData;
    else if (strobe.shiftTx) txSr <= {txSr[BYTE_W-2:0], 1'b1};
  end

  assign rxByte = rxSr;
  assign txBit  = txSr[BYTE_W-1];

  // R5: pointer never leaves the register range
  p_ptr_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    int'(ptr) <= LAST);

  // R5: below the top an advance moves exactly one step
  p_inc_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incPtr && !strobe.loadPtr && ptr != PTR_W'(LAST)) |=> ptr == PTR_W'($past(ptr) + 1'b1));

  // R5: at the top an advance holds the pointer
  p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incPtr && !strobe.loadPtr && ptr == PTR_W'(LAST)) |=> ptr == PTR_W'(LAST));

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h63,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  strobe,
  output logic       sdaBit,
  output logic       sdaOe
);

  localparam int BITS  = 8;
  localparam int CNT_W = $clog2(BITS + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startSeen, stopSeen;

  busState_t         state, stateN;
  phase_t            phase, phaseN;
  logic [CNT_W-1:0]  bitCnt, bitCntN;
  logic              readMode, readN;
  logic              masterNack, nackN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS      = sclSync[SYNC_STAGES-1];
  assign sdaS      = sdaSync[SYNC_STAGES-1];
  assign sclRise   = sclS && !sclD;
  assign sclFall   = !sclS && sclD;
  assign startSeen = sclS && sclD && sdaD && !sdaS;
  assign stopSeen  = sclS && sclD && !sdaD && sdaS;
  assign sdaBit    = sdaS;

  always_comb begin
    stateN  = state;
    phaseN  = phase;
    bitCntN = bitCnt;
    readN   = readMode;
    nackN   = masterNack;
    strobe  = '0;
    if (startSeen) begin
      stateN  = S_RX;
      phaseN  = PH_ADDR;
      bitCntN = '0;
    end else if (stopSeen) begin
      stateN  = S_IDLE;
      bitCntN = '0;
    end else begin
      unique case (state)
        S_RX: begin
          if (sclRise && bitCnt != CNT_W'(BITS)) begin
            strobe.shiftIn = 1'b1;
            bitCntN = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == CNT_W'(BITS)) begin
            bitCntN = '0;
            unique case (phase)
              PH_ADDR: begin
                if (rxByte[7:1] == DEV_ADDR) begin
                  stateN = S_RX_ACK;
                  readN  = rxByte[0];
                end else begin
                  stateN = S_SKIP;
                end
              end
              PH_PTR: begin
                strobe.loadPtr = 1'b1;
                stateN = S_RX_ACK;
              end
              default: begin
                strobe.writeReg = 1'b1;
                strobe.incPtr   = 1'b1;
                stateN = S_RX_ACK;
              end
            endcase
          end
        end
        S_RX_ACK: begin
          if (sclFall) begin
            if (phase == PH_ADDR && readMode) begin
              strobe.loadTx = 1'b1;
              stateN = S_TX;
            end else begin
              stateN = S_RX;
              phaseN = (phase == PH_ADDR) ? PH_PTR : PH_DATA;
            end
          end
        end
        S_TX: begin
          if (sclRise) begin
            bitCntN = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == CNT_W'(BITS)) begin
              stateN  = S_TX_ACK;
              bitCntN = '0;
            end else begin
              strobe.shiftTx = 1'b1;
            end
          end
        end
        S_TX_ACK: begin
          if (sclRise) begin
            nackN = sdaS;
            strobe.incPtr = 1'b1;
          end else if (sclFall) begin
            if (masterNack) begin
              stateN = S_SKIP;
            end else begin
              strobe.loadTx = 1'b1;
              stateN = S_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      phase      <= PH_ADDR;
      bitCnt     <= '0;
      readMode   <= 1'b0;
      masterNack <= 1'b0;
    end else begin
      state      <= stateN;
      phase      <= phaseN;
      bitCnt     <= bitCntN;
      readMode   <= readN;
      masterNack <= nackN;
    end
  end

  assign sdaOe = (state == S_RX_ACK) || (state == S_TX && !txBit);

  // R9: the pull-down enable holds while SCL stays high
  p_oe_stable_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclD) |=> $stable(sdaOe));

  // R2: an address acknowledge needs a matching received byte
  p_ack_needs_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RX && stateN == S_RX_ACK && phase == PH_ADDR) |-> rxByte[7:1] == DEV_ADDR);

  // R3: a STOP leaves SDA released
  p_stop_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaOe);

  // R8: a master NACK on a read byte releases SDA at the next SCL fall
  p_nack_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TX_ACK && masterNack && sclFall && !startSeen && !stopSeen) |=> !sdaOe);

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h63,
  parameter int         NUM_REGS    = 23,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  dpStrobe_t  strobe;
  logic       sdaBit;
  logic [7:0] rxByte;
  logic       txBit;

  i2c_slave_ctrl #(
    .DEV_ADDR    (DEV_ADDR),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .rxByte (rxByte),
    .txBit  (txBit),
    .strobe (strobe),
    .sdaBit (sdaBit),
    .sdaOe  (sdaOe)
  );

  i2c_slave_dpath #(
    .NUM_REGS (NUM_REGS)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .sdaBit (sdaBit),
    .rxByte (rxByte),
    .txBit  (txBit)
  );

endmodule

// File: tb/sim_i2c_regfile_slave.sv
`timescale 1ns/1ps
module sim_i2c_regfile_slave;

  localparam int Q = 10;           // system clocks per quarter SCL period
  localparam int LASTREG = 22;
  localparam logic [7:0] AW = 8'hC6, AR = 8'hC7, BW = 8'hC4, BR = 8'hC5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic sdaOe;
  logic sdaLine;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] refRegs [0:LASTREG];
  int refPtr;

  always #2.5 clk = ~clk;

  assign sdaLine = mSda & ~sdaOe;

  i2c_regfile_slave u0 (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (scl),
    .sdaIn (sdaLine),
    .sdaOe (sdaOe)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic void mSetPtr(input logic [7:0] b);
    refPtr = (int'(b) > LASTREG) ? LASTREG : int'(b);
  endfunction

  function automatic void mStep();
    if (refPtr < LASTREG) refPtr++;
  endfunction

  function automatic void mWrite(input logic [7:0] b);
    refRegs[refPtr] = b;
    mStep();
  endfunction

  // one SCL period; sdaOe must equal expOe on every clock of the high phase (R9)
  task automatic bitSlot(input logic mBit, input logic expOe, input string req);
    int bad;
    logic act;
    mSda = mBit;
    waitClk(Q);
    scl = 1'b1;
    bad = 0;
    act = expOe;
    repeat (2 * Q) begin
      @(negedge clk);
      if (sdaOe !== expOe) begin
        bad++;
        act = sdaOe;
      end
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s R9 slot: sdaOe=%0b expected %0b", req, act, expOe);
    end
    scl = 1'b0;
    waitClk(Q);
  endtask

  task automatic busStart();
    mSda = 1'b1;
    waitClk(Q);
    scl = 1'b1;
    waitClk(Q);
    mSda = 1'b0;
    waitClk(Q);
    scl = 1'b0;
    waitClk(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0;
    waitClk(Q);
    scl = 1'b1;
    waitClk(Q);
    mSda = 1'b1;
    waitClk(2 * Q);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string req);
    for (int i = 7; i >= 0; i--) bitSlot(b[i], 1'b0, req);
    bitSlot(1'b1, expAck, req);
  endtask

  task automatic readByte(input logic masterAck, input string req);
    logic [7:0] e;
    e = refRegs[refPtr];
    for (int i = 7; i >= 0; i--) bitSlot(1'b1, ~e[i], req);
    bitSlot(~masterAck, 1'b0, req);
    mStep();
  endtask

  initial begin
    for (int i = 0; i <= LASTREG; i++) refRegs[i] = 8'h00;
    refPtr = 0;
    waitClk(10);
    rstN = 1'b1;
    waitClk(10);

    checks++;
    if (sdaOe !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: sdaOe=%0b expected 0", sdaOe);
    end

    // R1 / R7: read with no pointer phase starts at register 0; R8 NACK releases
    busStart();
    sendByte(AR, 1'b1, "R2 addr-read");
    readByte(1'b0, "R1 first read");
    bitSlot(1'b1, 1'b0, "R8 released after NACK");
    busStop();

    // R2: wrong address, bytes ignored
    busStart();
    sendByte(BW, 1'b0, "R2 wrong addr");
    sendByte(8'h03, 1'b0, "R2 ignored byte");
    sendByte(8'hFF, 1'b0, "R2 ignored byte");
    busStop();

    // R4: single write
    busStart();
    sendByte(AW, 1'b1, "R4 addr");
    sendByte(8'h03, 1'b1, "R4 pointer"); mSetPtr(8'h03);
    sendByte(8'hA5, 1'b1, "R4 data");    mWrite(8'hA5);
    busStop();

    // R5: burst write crossing the top register
    busStart();
    sendByte(AW, 1'b1, "R5 addr");
    sendByte(8'h14, 1'b1, "R5 pointer"); mSetPtr(8'h14);
    sendByte(8'h11, 1'b1, "R5 data"); mWrite(8'h11);
    sendByte(8'h22, 1'b1, "R5 data"); mWrite(8'h22);
    sendByte(8'h33, 1'b1, "R5 data"); mWrite(8'h33);
    sendByte(8'h44, 1'b1, "R5 data saturated"); mWrite(8'h44);
    busStop();

    // R6: random read via repeated START
    busStart();
    sendByte(AW, 1'b1, "R6 addr");
    sendByte(8'h03, 1'b1, "R6 pointer"); mSetPtr(8'h03);
    busStart();
    sendByte(AR, 1'b1, "R6 addr-read");
    readByte(1'b1, "R6 read 0x03");
    readByte(1'b1, "R6 read 0x04");
    readByte(1'b0, "R6 read 0x05");
    busStop();

    // R4: pointer above range clamps to the top register
    busStart();
    sendByte(AW, 1'b1, "R4 addr");
    sendByte(8'h40, 1'b1, "R4 clamp pointer"); mSetPtr(8'h40);
    sendByte(8'h99, 1'b1, "R4 clamp data"); mWrite(8'h99);
    busStop();

    // R7 / R5: current-address read stays at the top register
    busStart();
    sendByte(AR, 1'b1, "R7 addr-read");
    readByte(1'b1, "R7 current read");
    readByte(1'b0, "R5 read saturated");
    busStop();

    // R5: read crossing into the top register
    busStart();
    sendByte(AW, 1'b1, "R5 addr");
    sendByte(8'h15, 1'b1, "R5 pointer"); mSetPtr(8'h15);
    busStart();
    sendByte(AR, 1'b1, "R5 addr-read");
    readByte(1'b1, "R5 read 0x15");
    readByte(1'b1, "R5 read 0x16");
    readByte(1'b0, "R5 read 0x16 again");
    busStop();

    // R10: repeated START with write starts a new pointer phase
    busStart();
    sendByte(AW, 1'b1, "R10 addr");
    sendByte(8'h00, 1'b1, "R10 pointer"); mSetPtr(8'h00);
    busStart();
    sendByte(AW, 1'b1, "R10 addr again");
    sendByte(8'h01, 1'b1, "R10 new pointer"); mSetPtr(8'h01);
    sendByte(8'h77, 1'b1, "R10 data"); mWrite(8'h77);
    busStart();
    sendByte(AW, 1'b1, "R10 addr");
    sendByte(8'h00, 1'b1, "R10 pointer"); mSetPtr(8'h00);
    busStart();
    sendByte(AR, 1'b1, "R10 addr-read");
    readByte(1'b1, "R10 read 0x00");
    readByte(1'b1, "R10 read 0x01");
    readByte(1'b0, "R10 read 0x02");
    busStop();

    // R2: wrong address read: no ack, no data driven, pointer untouched
    busStart();
    sendByte(BR, 1'b0, "R2 wrong addr-read");
    for (int i = 0; i < 9; i++) bitSlot(1'b1, 1'b0, "R2 quiet");
    busStop();
    busStart();
    sendByte(AR, 1'b1, "R2 addr-read");
    readByte(1'b0, "R2 pointer kept");
    busStop();

    // R3: START then STOP at once, then START mid-byte restarts the address phase
    busStart();
    busStop();
    busStart();
    bitSlot(1'b1, 1'b0, "R3 partial");
    bitSlot(1'b0, 1'b0, "R3 partial");
    busStart();
    sendByte(AR, 1'b1, "R3 addr after restart");
    readByte(1'b0, "R3 read continues");
    busStop();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R3 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule